// File: doc/BRIEF.md
# Serial-Access Byte Memory Slave

This block is a byte-wide memory that is reached over a four-wire serial link in SPI mode 0. It has a select line (active low), a serial clock, a data input and a data output. A host lowers the select line and shifts in an 8-bit opcode. A read or write opcode is followed by a 16-bit address, and then by any number of data bytes. Every field travels most significant bit first. The host samples on the rising edge of the serial clock, and the block changes its output on the falling edge. All serial inputs are resynchronised into the system clock domain, so the serial clock must be several system clock periods slower.

After each complete data byte, an internal pointer advances. A configuration opcode sets one of three sequencing schemes:

- **Single:** one byte per transfer.
- **Page:** the pointer loops inside a 32-byte page.
- **Linear:** writes step straight through the array and roll over at the top. Reads first finish a full lap of the current page, then carry on at the same offset in the following page.

The storage depth is set by the address width parameter. Any address bits above that width are ignored.

Top module: `spi_sram_slave`

## Requirements
- R1: While `sel_n` is high, the block waits for a new opcode and `dout_en` is low. Raising `sel_n` ends any transfer.
- R2: The first 8 bits after `sel_n` falls form the opcode, sampled on `ser_clk` rising edges, MSB first.
  - 0x02 is write, 0x03 is read and 0x01 is configure.
  - Any other opcode makes the block ignore everything, with no store and `dout_en` low, until `sel_n` rises.
- R3: A read or write opcode is followed by a 16-bit address, MSB first. Only the low `ADDR_W` bits are kept, so bit 15 and every bit above the array width are ignored.
- R4: During a write, each complete 8-bit data byte (MSB first) replaces the stored byte at the pointer. `dout_en` stays low for the whole write.
- R5: During a read, bit 7 of the byte at the pointer appears on `dout` at the `ser_clk` falling edge that follows the last address bit. Each later falling edge presents the next lower bit, and `dout_en` is high.
- R6: Opcode 0x01 followed by one byte sets the sequencing scheme from bits 7:6.
  - 00 selects single, 10 selects page and 01 selects linear. 11 also selects single.
  - After reset the scheme is single.
- R7: In single mode, a transfer handles exactly one data byte. Later clocks store nothing, and `dout_en` drops at the next falling edge; this lasts until `sel_n` rises.
- R8: In page mode, the low 5 pointer bits (the offset in the page) step by one after each byte. Offset 31 is followed by offset 0 of the same page, and this repeats without limit, for both reads and writes.
- R9: In linear mode, a write steps the pointer by one after each byte. The highest address is followed by address 0.
- R10: In linear mode, a read steps the offset within the page, with 31 followed by 0. When the offset comes back to the starting offset, the pointer moves to that same offset in the next page. The next page after the last one is page 0.
- R11: A data byte that is only partly shifted in when `sel_n` rises is discarded, and memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| dout_en | output | 1 | Output enable for `dout` (low means high impedance) |

## Verification
The bench builds the block with `ADDR_W` = 9 and `PAGE_W` = 5, which gives 16 pages of 32 bytes. With this size, a single linear write of 512 bytes covers the whole array and crosses the rollover from the top address to 0. A linear read that starts at offset 16 of the last page can then be followed through its page lap and on into page 0. It uses a 6-cycle serial half period, which leaves enough margin over the two-stage input synchroniser for the output to settle before each sampling edge.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADR,
        ST_CFG,
        ST_WR,
        ST_RD,
        ST_IGN
    } phase_e;

    typedef enum logic [1:0] {
        SEQ_ONE    = 2'b00,
        SEQ_LINEAR = 2'b01,
        SEQ_PAGE   = 2'b10
    } seq_e;

    localparam logic [7:0] OPC_CFG = 8'h01;
    localparam logic [7:0] OPC_WR  = 8'h02;
    localparam logic [7:0] OPC_RD  = 8'h03;

    localparam int OPC_BITS = 8;
    localparam int ADR_BITS = 16;

endpackage

// File: rtl/spi_sram_sync.sv
module spi_sram_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_i,
    input  logic sclk_i,
    input  logic din_i,
    output logic sel_idle_o,
    output logic din_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] sel_q, sel_d;
    logic [STAGES-1:0] sclk_q, sclk_d;
    logic [STAGES-1:0] din_q, din_d;
    logic              prev_q, prev_d;

    always_comb begin
        sel_d  = {sel_q[STAGES-2:0], sel_n_i};
        sclk_d = {sclk_q[STAGES-2:0], sclk_i};
        din_d  = {din_q[STAGES-2:0], din_i};
        prev_d = sclk_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '1;
            sclk_q <= '0;
            din_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            sel_q  <= sel_d;
            sclk_q <= sclk_d;
            din_q  <= din_d;
            prev_q <= prev_d;
        end
    end

    assign sel_idle_o = sel_q[STAGES-1];
    assign din_o      = din_q[STAGES-1];
    assign rise_o     = sclk_q[STAGES-1] & ~prev_q;
    assign fall_o     = ~sclk_q[STAGES-1] & prev_q;

endmodule

// File: rtl/spi_sram_step.sv
module spi_sram_step
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 5
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [PAGE_W-1:0] start_i,
    input  seq_e              seq_i,
    input  logic              rd_i,
    output logic [ADDR_W-1:0] nxt_o
);

    localparam int PG_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] off_inc;
    logic [PG_W-1:0]   page;

    always_comb begin
        off_inc = ptr_i[PAGE_W-1:0] + 1'b1;
        page    = ptr_i[ADDR_W-1:PAGE_W];
        unique case (seq_i)
            SEQ_PAGE:   nxt_o = {page, off_inc};
            SEQ_LINEAR: begin
                if (!rd_i)
                    nxt_o = ptr_i + 1'b1;
                else if (off_inc == start_i)
                    nxt_o = {page + 1'b1, start_i};
                else
                    nxt_o = {page, off_inc};
            end
            default:    nxt_o = ptr_i;
        endcase
    end

endmodule

// File: rtl/spi_sram_array.sv
module spi_sram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic ser_clk,
    input  logic din,
    output logic dout,
    output logic dout_en
);

    localparam int CNT_W = $clog2(ADR_BITS);
    localparam int PG_W  = ADDR_W - PAGE_W;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [6:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic [PAGE_W-1:0] start;
        seq_e              seq;
        logic              rd;
        logic [7:0]        tx;
        logic              load;
        logic              oe;
    } regs_t;

    regs_t q, d;

    logic              sel_idle, din_s, rise, fall;
    logic [7:0]        full;
    logic [ADDR_W-1:0] ptr_nxt;
    logic [7:0]        rd_data;
    logic              wr_en;
    logic              word_done;

    spi_sram_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n_i    (sel_n),
        .sclk_i     (ser_clk),
        .din_i      (din),
        .sel_idle_o (sel_idle),
        .din_o      (din_s),
        .rise_o     (rise),
        .fall_o     (fall)
    );

    spi_sram_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
        .ptr_i   (q.ptr),
        .start_i (q.start),
        .seq_i   (q.seq),
        .rd_i    (q.rd),
        .nxt_o   (ptr_nxt)
    );

    spi_sram_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk     (clk),
        .we_i    (wr_en),
        .waddr_i (q.ptr),
        .wdata_i (full),
        .raddr_i (q.ptr),
        .rdata_o (rd_data)
    );

    function automatic seq_e decode_seq(input logic [1:0] f);
        unique case (f)
            2'b10:   return SEQ_PAGE;
            2'b01:   return SEQ_LINEAR;
            default: return SEQ_ONE;
        endcase
    endfunction

    assign full = {q.sh, din_s};

    always_comb begin
        d         = q;
        wr_en     = 1'b0;
        word_done = 1'b0;
        if (sel_idle) begin
            d.phase = ST_OPC;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.load  = 1'b0;
        end else if (rise) begin
            d.sh  = full[6:0];
            d.cnt = q.cnt + 1'b1;
            unique case (q.phase)
                ST_OPC: begin
                    if (q.cnt == CNT_W'(OPC_BITS - 1)) begin
                        d.cnt = '0;
                        if (full == OPC_WR) begin
                            d.phase = ST_ADR;
                            d.rd    = 1'b0;
                        end else if (full == OPC_RD) begin
                            d.phase = ST_ADR;
                            d.rd    = 1'b1;
                        end else if (full == OPC_CFG) begin
                            d.phase = ST_CFG;
                        end else begin
                            d.phase = ST_IGN;
                        end
                    end
                end
                ST_ADR: begin
                    d.ptr = {q.ptr[ADDR_W-2:0], din_s};
                    if (q.cnt == CNT_W'(ADR_BITS - 1)) begin
                        d.cnt   = '0;
                        d.start = d.ptr[PAGE_W-1:0];
                        d.phase = q.rd ? ST_RD : ST_WR;
                        d.load  = q.rd;
                    end
                end
                ST_CFG: begin
                    if (q.cnt == CNT_W'(OPC_BITS - 1)) begin
                        d.seq   = decode_seq(full[7:6]);
                        d.phase = ST_IGN;
                    end
                end
                ST_WR: begin
                    if (q.cnt == CNT_W'(OPC_BITS - 1)) begin
                        d.cnt     = '0;
                        wr_en     = 1'b1;
                        word_done = 1'b1;
                        d.ptr     = ptr_nxt;
                        if (q.seq == SEQ_ONE) d.phase = ST_IGN;
                    end
                end
                ST_RD: begin
                    if (q.cnt == CNT_W'(OPC_BITS - 1)) begin
                        d.cnt     = '0;
                        word_done = 1'b1;
                        d.ptr     = ptr_nxt;
                        if (q.seq == SEQ_ONE) begin
                            d.phase = ST_IGN;
                            d.load  = 1'b0;
                        end else begin
                            d.load  = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end else if (fall) begin
            if (q.phase == ST_RD) begin
                if (q.load) begin
                    d.tx   = rd_data;
                    d.load = 1'b0;
                    d.oe   = 1'b1;
                end else begin
                    d.tx = {q.tx[6:0], 1'b0};
                end
            end else begin
                d.oe = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= ST_OPC;
            q.cnt   <= '0;
            q.sh    <= '0;
            q.ptr   <= '0;
            q.start <= '0;
            q.seq   <= SEQ_ONE;
            q.rd    <= 1'b0;
            q.tx    <= '0;
            q.load  <= 1'b0;
            q.oe    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dout    = q.tx[7];
    assign dout_en = q.oe;

    a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
        sel_idle |=> !dout_en);

    a_r4_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_WR) |-> !dout_en);

    a_r5_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_RD && fall && !sel_idle) |=> dout_en);

    a_r7_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && q.seq == SEQ_ONE) |=> (q.phase == ST_IGN));

    a_r8_page_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && q.seq == SEQ_PAGE)
        |=> (q.ptr[ADDR_W-1:PAGE_W] == $past(q.ptr[ADDR_W-1:PAGE_W])));

    a_r9_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.seq == SEQ_LINEAR) |=> (q.ptr == $past(q.ptr) + 1'b1));

    a_r10_page_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && q.rd && q.seq == SEQ_LINEAR)
        |=> ((q.ptr[PAGE_W-1:0] != q.start)
             || (q.ptr[ADDR_W-1:PAGE_W] == PG_W'($past(q.ptr[ADDR_W-1:PAGE_W]) + 1'b1))));

endmodule

// File: tb/spi_sram_slave_tb.sv
module spi_sram_slave_tb;

    localparam int TB_AW  = 9;
    localparam int TB_PW  = 5;
    localparam int MEMSZ  = 1 << TB_AW;
    localparam int PSZ    = 1 << TB_PW;
    localparam int NPG    = MEMSZ / PSZ;
    localparam int HALF   = 6;

    typedef struct {
        logic [7:0] v;
        string      tag;
        int         addr;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic ser_clk = 1'b0;
    logic din = 1'b0;
    logic dout, dout_en;

    int n_checks = 0;
    int n_errors = 0;
    int bmode = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [MEMSZ];
    exp_t       exp_q [$];
    logic [7:0] got_q [$];

    always #2 clk = ~clk;

    spi_sram_slave #(.ADDR_W(TB_AW), .PAGE_W(TB_PW), .SYNC_STAGES(2)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .ser_clk (ser_clk),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int step(input int a, input int start, input int m, input bit rd);
        int off;
        int pg;
        off = (a + 1) % PSZ;
        pg  = a / PSZ;
        if (m == 2) return pg * PSZ + off;
        if (m == 1) begin
            if (!rd) return (a + 1) % MEMSZ;
            if (off == start) return ((pg + 1) % NPG) * PSZ + start;
            return pg * PSZ + off;
        end
        return a;
    endfunction

    task automatic send_byte(input logic [7:0] b, input int nbits,
                             output logic [7:0] got, output bit en_any, output bit en_all);
        got = 8'h00;
        en_any = 1'b0;
        en_all = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            din = b[7-i];
            repeat (HALF) @(negedge clk);
            got = {got[6:0], dout};
            if (dout_en) en_any = 1'b1;
            else en_all = 1'b0;
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic begin_txn();
        @(negedge clk);
        sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_txn(input string tag);
        repeat (HALF) @(negedge clk);
        sel_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        check(dout_en == 1'b0, tag, "dout_en after select release", dout_en, 0);
    endtask

    task automatic send_hdr(input logic [7:0] opc, input logic [15:0] a);
        logic [7:0] g;
        bit ea, el;
        send_byte(opc, 8, g, ea, el);
        send_byte(a[15:8], 8, g, ea, el);
        send_byte(a[7:0], 8, g, ea, el);
    endtask

    task automatic set_mode(input logic [7:0] m);
        logic [7:0] g;
        bit ea, el;
        begin_txn();
        send_byte(8'h01, 8, g, ea, el);
        send_byte(m, 8, g, ea, el);
        end_txn("R6");
        bmode = (m[7:6] == 2'b10) ? 2 : (m[7:6] == 2'b01) ? 1 : 0;
    endtask

    task automatic do_write(input logic [15:0] a16, input int n, input int part,
                            input logic [7:0] seed, input string tag);
        int a;
        int st;
        bit any_en;
        logic [7:0] g;
        bit ea, el;
        a = a16 % MEMSZ;
        st = a % PSZ;
        any_en = 1'b0;
        begin_txn();
        send_hdr(8'h02, a16);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = seed + 8'(k * 37);
            send_byte(v, 8, g, ea, el);
            if (ea) any_en = 1'b1;
            if (bmode != 0 || k == 0) ref_mem[a] = v;
            a = step(a, st, bmode, 1'b0);
        end
        if (part > 0) begin
            send_byte(8'hFF, part, g, ea, el);
            if (ea) any_en = 1'b1;
        end
        check(!any_en, "R4", "dout_en seen during write", any_en, 0);
        end_txn(tag);
    endtask

    task automatic do_read(input logic [15:0] a16, input int n, input string tag);
        int a;
        int st;
        logic [7:0] g;
        bit ea, el;
        a = a16 % MEMSZ;
        st = a % PSZ;
        begin_txn();
        send_hdr(8'h03, a16);
        for (int k = 0; k < n; k++) begin
            send_byte(8'h00, 8, g, ea, el);
            if (bmode == 0 && k > 0) begin
                check(!ea, "R7", "dout_en after single byte", ea, 0);
            end else begin
                exp_t e;
                e.v = ref_mem[a];
                e.tag = tag;
                e.addr = a;
                exp_q.push_back(e);
                got_q.push_back(g);
                if (k == 0) check(el, "R5", "dout_en during first read byte", el, 1);
                a = step(a, st, bmode, 1'b1);
            end
        end
        end_txn("R1");
    endtask

    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                exp_t e;
                logic [7:0] g;
                e = exp_q.pop_front();
                g = got_q.pop_front();
                check(g === e.v, e.tag, $sformatf("read data at 0x%0h", e.addr), g, e.v);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] g;
        bit ea, el;
        any_init : for (int i = 0; i < MEMSZ; i++) ref_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(dout_en == 1'b0, "R1", "dout_en after reset", dout_en, 0);

        // R6 default single mode, R7 extra byte ignored
        do_write(16'h0020, 2, 0, 8'h5A, "R6");
        do_read(16'h0020, 2, "R6");

        // R9 linear fill of whole array crossing top, with R3 high bits set
        set_mode(8'h40);
        do_write(16'hFDF0, MEMSZ, 0, 8'h03, "R9");
        do_read(16'h0000, 4, "R9");
        do_read(16'h01F0, 40, "R10");

        // R8 page loop for writes and reads
        set_mode(8'h80);
        do_write(16'h005C, 6, 0, 8'hA0, "R8");
        do_read(16'h005E, 5, "R8");
        do_read(16'h0041, 34, "R8");

        // R7 single mode stops after one byte
        set_mode(8'h00);
        do_write(16'h0100, 2, 0, 8'hC3, "R7");
        do_read(16'h0101, 1, "R7");
        do_read(16'h0100, 2, "R7");

        // R3 ignored address bits
        do_read(16'h7E05, 1, "R3");
        do_read(16'h8005, 1, "R3");

        // R6 code 11 selects single
        set_mode(8'hC0);
        do_write(16'h0120, 2, 0, 8'h44, "R6");
        do_read(16'h0121, 1, "R6");
        do_read(16'h0120, 1, "R6");

        // R2 unknown opcode ignored
        begin_txn();
        send_hdr(8'h05, 16'h0130);
        send_byte(8'hEE, 8, g, ea, el);
        check(!ea, "R2", "dout_en after unknown opcode", ea, 0);
        end_txn("R2");
        do_read(16'h0130, 1, "R2");

        // R11 partial byte discarded
        set_mode(8'h40);
        do_write(16'h0150, 1, 3, 8'h6B, "R11");
        do_read(16'h0150, 2, "R11");
        set_mode(8'h00);
        do_write(16'h0160, 0, 5, 8'h00, "R11");
        do_read(16'h0160, 1, "R11");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule